// File: doc/BRIEF.md
# Configurable Serial Audio Port

This block moves stereo PCM between 24-bit parallel samples and a serial data line. It has a receiver and a transmitter that share one externally supplied bit clock, running at 64 times the sample rate, and one word clock, running at the sample rate. Every word-clock period holds a left and a right subframe of 32 bit slots each. The block samples both clocks in its own system clock domain and finds their edges there. It generates no clock and does not measure the sample rate.

A two-bit format field picks the placement of a word inside its subframe. The word can start at the first slot with no delay, start one slot late, or be packed against the end of the subframe so that its LSB fills the last slot. In the packed style, a two-bit length field sets the word length. One polarity bit flips which word-clock level marks the left subframe. A second polarity bit picks the bit-clock edge on which data is sampled; outgoing data changes on the opposite edge.

A small state machine follows the subframes and has three states. HUNT is the state after reset. LEFT_SUB is entered when a left subframe begins, either from HUNT or from RIGHT_SUB. RIGHT_SUB is entered from LEFT_SUB when a right subframe begins. The step from RIGHT_SUB to LEFT_SUB marks a completed frame. On that step the receiver presents both samples and raises its strobe.

Top module: `sap_port`

## Requirements
- R1: During reset and right after it, rx_left, rx_right, rx_valid, tx_load and sdo are all 0.
- R2: With cfg_wpol=0, the left subframe is the period in which wclk is high. With cfg_wpol=1, the left subframe is the period in which wclk is low.
- R3: With cfg_bpol=0, sdi is sampled on rising bclk edges, and with cfg_bpol=1 on falling edges. sdo changes only on the opposite (inactive) edges. A subframe starts at the first sampling edge after wclk changes level, and that edge is slot 0.
- R4: cfg_fmt=00 places a 24-bit word MSB first in slots 0 to 23 of each subframe.
- R5: cfg_fmt=10 places a 24-bit word MSB first in slots 1 to 24, one slot later than R4.
- R6: cfg_fmt=01 packs the word so that its LSB is in slot 31. cfg_len 00, 01, 10 and 11 set word lengths of 24, 20, 18 and 16 bits.
- R7: cfg_len has no effect when cfg_fmt is 00 or 10. The reserved code cfg_fmt=11 behaves exactly like 00.
- R8: At the first sampling edge of a left subframe that follows a right subframe, rx_left and rx_right show the words received in that frame, and rx_valid is high for exactly one clk cycle. Result bits below the word length are 0, and sdi values in slots outside the word are ignored.
- R9: sdo is 0 in every slot outside the active word, and also before the first samples have been loaded.
- R10: tx_left and tx_right are captured together at the inactive edge just before slot 0 of each left subframe. tx_load pulses for one cycle there, once per frame.
- R11: rx_left and rx_right hold their values between rx_valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bclk and wclk are synchronous to it and much slower |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 2 | Placement style: 00 no delay, 10 one-slot delay, 01 LSB-packed, 11 reserved (as 00) |
| cfg_len | input | 2 | Word length in the LSB-packed style: 00=24, 01=20, 10=18, 11=16 |
| cfg_wpol | input | 1 | Word-clock polarity: 0 means left while wclk is high |
| cfg_bpol | input | 1 | Bit-clock polarity: 0 samples on rising edges |
| bclk | input | 1 | Bit clock, 64 periods per frame |
| wclk | input | 1 | Word clock, one period per frame |
| sdi | input | 1 | Serial data into the receiver |
| rx_left | output | 24 | Last received left sample, MSB-aligned |
| rx_right | output | 24 | Last received right sample, MSB-aligned |
| rx_valid | output | 1 | One-cycle strobe when a new pair is presented |
| tx_left | input | 24 | Left sample to send, MSB-aligned |
| tx_right | input | 24 | Right sample to send, MSB-aligned |
| tx_load | output | 1 | One-cycle pulse when tx_left and tx_right are captured |
| sdo | output | 1 | Serial data out of the transmitter |

## Verification
The assertions assume that bclk and wclk are synchronous to clk and that each level of bclk lasts at least one clk cycle, so every bit-clock edge appears as exactly one event cycle. They also assume that wclk changes only together with an inactive bit-clock edge. The stimulus meets these assumptions: it drives bclk with three clk cycles per level, and it moves wclk and sdi only at the same moment as the inactive edge. Configuration inputs change only between frames. The frame after each configuration change is discarded, so no check depends on a frame that straddles the change.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Word placement codes carried by cfg_fmt
    typedef enum logic [1:0] {
        FMT_NODELAY = 2'b00,
        FMT_LSBJ    = 2'b01,
        FMT_DELAY1  = 2'b10,
        FMT_RSVD    = 2'b11
    } sap_fmt_e;

    // Subframe tracking states
    typedef enum logic [1:0] {
        ST_HUNT  = 2'b00,
        ST_LEFT  = 2'b01,
        ST_RIGHT = 2'b10
    } sap_state_e;

    // Bits removed from the full sample width for each cfg_len code
    function automatic int trim_bits(input logic [1:0] len);
        case (len)
            2'b00:   return 0;
            2'b01:   return 4;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/sap_slot_map.sv
// Maps a slot index inside a subframe to a sample bit position.
module sap_slot_map
    import sap_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SUB_SLOTS = 32,
    localparam int SLOT_W   = $clog2(SUB_SLOTS),
    localparam int POS_W    = $clog2(SAMPLE_W)
) (
    input  logic [1:0]        fmt,
    input  logic [1:0]        len,
    input  logic [SLOT_W-1:0] slot,
    output logic              in_win,
    output logic [POS_W-1:0]  pos
);

    int wlen;
    int first;
    int off;

    always_comb begin
        wlen  = SAMPLE_W;
        first = 0;
        unique case (sap_fmt_e'(fmt))
            FMT_LSBJ: begin
                wlen  = SAMPLE_W - trim_bits(len);
                first = SUB_SLOTS - wlen;
            end
            FMT_DELAY1: first = 1;
            FMT_NODELAY, FMT_RSVD: first = 0;
        endcase
        off    = int'(slot) - first;
        in_win = (off >= 0) && (off < wlen);
        pos    = in_win ? POS_W'(SAMPLE_W - 1 - off) : '0;
    end

endmodule

// File: rtl/sap_clkedge.sv
// Finds bit-clock edges in the clk domain and classifies them.
module sap_clkedge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic wclk,
    input  logic bpol,
    input  logic wpol,
    output logic ev_act,
    output logic ev_inact,
    output logic is_left
);

    logic bclk_q;
    logic toggled;
    logic act_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    always_comb begin
        toggled   = bclk ^ bclk_q;
        act_level = bclk ^ bpol;
        ev_act    = toggled & act_level;
        ev_inact  = toggled & ~act_level;
        is_left   = wclk ^ wpol;
    end

endmodule

// File: rtl/sap_seq.sv
// Subframe state machine and slot counter.
module sap_seq
    import sap_pkg::*;
#(
    parameter int SUB_SLOTS = 32,
    localparam int SLOT_W   = $clog2(SUB_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_act,
    input  logic              is_left,
    output sap_state_e        state,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              sub_start,
    output logic              frame_done
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SUB_SLOTS - 1);

    sap_state_e        state_nxt;
    logic              last_left;
    logic [SLOT_W-1:0] cnt;

    // Slot that the next bit-clock edge belongs to
    always_comb begin
        sub_start = is_left ^ last_left;
        if (sub_start)              slot_nxt = '0;
        else if (cnt == SLOT_LAST)  slot_nxt = cnt;
        else                        slot_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            last_left <= 1'b0;
        end else if (ev_act) begin
            cnt       <= slot_nxt;
            last_left <= is_left;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT:  if (ev_act && sub_start && is_left)  state_nxt = ST_LEFT;
            ST_LEFT:  if (ev_act && sub_start && !is_left) state_nxt = ST_RIGHT;
            ST_RIGHT: if (ev_act && sub_start && is_left)  state_nxt = ST_LEFT;
            default:  state_nxt = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // Outputs
    always_comb begin
        frame_done = (state == ST_RIGHT) && ev_act && sub_start && is_left;
    end

endmodule

// File: rtl/sap_rx.sv
// Serial-to-parallel receiver.
module sap_rx #(
    parameter int SAMPLE_W  = 24,
    parameter int SUB_SLOTS = 32,
    localparam int SLOT_W   = $clog2(SUB_SLOTS),
    localparam int POS_W    = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt,
    input  logic [1:0]          len,
    input  logic                ev_act,
    input  logic                is_left,
    input  logic                sub_start,
    input  logic                frame_done,
    input  logic [SLOT_W-1:0]   slot,
    input  logic                sdi,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    logic                in_win;
    logic [POS_W-1:0]    pos;
    logic [SAMPLE_W-1:0] bit_mask;
    logic [SAMPLE_W-1:0] acc_l;
    logic [SAMPLE_W-1:0] acc_r;

    sap_slot_map #(.SAMPLE_W(SAMPLE_W), .SUB_SLOTS(SUB_SLOTS)) u_map (
        .fmt    (fmt),
        .len    (len),
        .slot   (slot),
        .in_win (in_win),
        .pos    (pos)
    );

    always_comb begin
        bit_mask = (in_win && sdi) ? (SAMPLE_W'(1) << pos) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_l <= '0;
            acc_r <= '0;
        end else if (ev_act) begin
            if (is_left) acc_l <= (sub_start ? '0 : acc_l) | bit_mask;
            else         acc_r <= (sub_start ? '0 : acc_r) | bit_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= frame_done;
            if (frame_done) begin
                rx_left  <= acc_l;
                rx_right <= acc_r;
            end
        end
    end

endmodule

// File: rtl/sap_tx.sv
// Parallel-to-serial transmitter.
module sap_tx #(
    parameter int SAMPLE_W  = 24,
    parameter int SUB_SLOTS = 32,
    localparam int SLOT_W   = $clog2(SUB_SLOTS),
    localparam int POS_W    = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt,
    input  logic [1:0]          len,
    input  logic                ev_inact,
    input  logic                is_left,
    input  logic                sub_start,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_load,
    output logic                sdo
);

    logic                in_win;
    logic [POS_W-1:0]    pos;
    logic [SAMPLE_W-1:0] hold_l;
    logic [SAMPLE_W-1:0] hold_r;
    logic                armed;
    logic                load_now;
    logic [SAMPLE_W-1:0] src;
    logic                bit_out;

    sap_slot_map #(.SAMPLE_W(SAMPLE_W), .SUB_SLOTS(SUB_SLOTS)) u_map (
        .fmt    (fmt),
        .len    (len),
        .slot   (slot),
        .in_win (in_win),
        .pos    (pos)
    );

    always_comb begin
        load_now = ev_inact && sub_start && is_left;
        if (is_left) src = load_now ? tx_left : hold_l;
        else         src = hold_r;
        bit_out = (armed || load_now) && in_win && src[pos];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l  <= '0;
            hold_r  <= '0;
            armed   <= 1'b0;
            tx_load <= 1'b0;
            sdo     <= 1'b0;
        end else begin
            tx_load <= load_now;
            if (load_now) begin
                hold_l <= tx_left;
                hold_r <= tx_right;
                armed  <= 1'b1;
            end
            if (ev_inact) sdo <= bit_out;
        end
    end

endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SUB_SLOTS = 32,
    localparam int SLOT_W   = $clog2(SUB_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_fmt,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_wpol,
    input  logic                cfg_bpol,
    input  logic                bclk,
    input  logic                wclk,
    input  logic                sdi,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_load,
    output logic                sdo
);

    logic              ev_act;
    logic              ev_inact;
    logic              is_left;
    sap_state_e        state;
    logic [SLOT_W-1:0] slot_nxt;
    logic              sub_start;
    logic              frame_done;

    sap_clkedge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .wclk     (wclk),
        .bpol     (cfg_bpol),
        .wpol     (cfg_wpol),
        .ev_act   (ev_act),
        .ev_inact (ev_inact),
        .is_left  (is_left)
    );

    sap_seq #(.SUB_SLOTS(SUB_SLOTS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_act     (ev_act),
        .is_left    (is_left),
        .state      (state),
        .slot_nxt   (slot_nxt),
        .sub_start  (sub_start),
        .frame_done (frame_done)
    );

    sap_rx #(.SAMPLE_W(SAMPLE_W), .SUB_SLOTS(SUB_SLOTS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (cfg_fmt),
        .len        (cfg_len),
        .ev_act     (ev_act),
        .is_left    (is_left),
        .sub_start  (sub_start),
        .frame_done (frame_done),
        .slot       (slot_nxt),
        .sdi        (sdi),
        .rx_left    (rx_left),
        .rx_right   (rx_right),
        .rx_valid   (rx_valid)
    );

    sap_tx #(.SAMPLE_W(SAMPLE_W), .SUB_SLOTS(SUB_SLOTS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (cfg_fmt),
        .len       (cfg_len),
        .ev_inact  (ev_inact),
        .is_left   (is_left),
        .sub_start (sub_start),
        .slot      (slot_nxt),
        .tx_left   (tx_left),
        .tx_right  (tx_right),
        .tx_load   (tx_load),
        .sdo       (sdo)
    );

endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ev_act,
    input logic                ev_inact,
    input logic                rx_valid,
    input logic [SAMPLE_W-1:0] rx_left,
    input logic [SAMPLE_W-1:0] rx_right,
    input logic                tx_load,
    input logic                sdo
);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    valid_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(ev_act));

    // R11
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

    // R3
    sdo_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(ev_inact));

    // R10
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    // R10
    load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(ev_inact));

endmodule

bind sap_port sap_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_act   (ev_act),
    .ev_inact (ev_inact),
    .rx_valid (rx_valid),
    .rx_left  (rx_left),
    .rx_right (rx_right),
    .tx_load  (tx_load),
    .sdo      (sdo)
);

// File: tb/sim_sap_port.sv
module sim_sap_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int SW         = 24;
    localparam int SLOTS      = 32;
    localparam int WATCHDOG   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_fmt = 2'b00;
    logic [1:0]    cfg_len = 2'b00;
    logic          cfg_wpol = 1'b0;
    logic          cfg_bpol = 1'b0;
    logic          bclk = 1'b0;
    logic          wclk = 1'b0;
    logic          sdi = 1'b0;
    logic [SW-1:0] rx_left;
    logic [SW-1:0] rx_right;
    logic          rx_valid;
    logic [SW-1:0] tx_left = '0;
    logic [SW-1:0] tx_right = '0;
    logic          tx_load;
    logic          sdo;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [SW-1:0] cap_l = '0;
    logic [SW-1:0] cap_r = '0;
    int            cap_n = 0;
    int            load_n = 0;

    sap_port #(.SAMPLE_W(SW), .SUB_SLOTS(SLOTS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_len(cfg_len),
        .cfg_wpol(cfg_wpol), .cfg_bpol(cfg_bpol), .bclk(bclk), .wclk(wclk),
        .sdi(sdi), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
        .tx_left(tx_left), .tx_right(tx_right), .tx_load(tx_load), .sdo(sdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                cap_l = rx_left;
                cap_r = rx_right;
                cap_n = cap_n + 1;
            end
            if (tx_load) load_n = load_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wlen(input logic [1:0] f, input logic [1:0] l);
        if (f != 2'b01) return SW;
        case (l)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 18;
            default: return 16;
        endcase
    endfunction

    function automatic int wfirst(input logic [1:0] f, input logic [1:0] l);
        if (f == 2'b10) return 1;
        if (f == 2'b01) return SLOTS - wlen(f, l);
        return 0;
    endfunction

    function automatic logic [SW-1:0] keep(input logic [SW-1:0] v);
        return v & ({SW{1'b1}} << (SW - wlen(cfg_fmt, cfg_len)));
    endfunction

    // Expected sdo pattern for one frame (bit g = slot g, left slots 0..31)
    function automatic logic [63:0] tx_expect(input logic [SW-1:0] l,
                                              input logic [SW-1:0] r);
        logic [63:0] e;
        for (int g = 0; g < 64; g++) begin
            int s   = g % SLOTS;
            int off = s - wfirst(cfg_fmt, cfg_len);
            logic [SW-1:0] smp = (g < SLOTS) ? l : r;
            e[g] = (off >= 0 && off < wlen(cfg_fmt, cfg_len)) ? smp[SW-1-off] : 1'b0;
        end
        return e;
    endfunction

    // One frame: drive sdi with word bits (ones outside the word), record sdo
    task automatic run_frame(input logic [SW-1:0] l, input logic [SW-1:0] r,
                             output logic [63:0] seen);
        for (int g = 0; g < 64; g++) begin
            int s   = g % SLOTS;
            int off = s - wfirst(cfg_fmt, cfg_len);
            logic [SW-1:0] smp = (g < SLOTS) ? l : r;
            @(negedge clk);
            bclk = cfg_bpol;
            wclk = (g < SLOTS) ? ~cfg_wpol : cfg_wpol;
            sdi  = (off >= 0 && off < wlen(cfg_fmt, cfg_len)) ? smp[SW-1-off] : 1'b1;
            repeat (HALF) @(negedge clk);
            seen[g] = sdo;
            bclk = ~cfg_bpol;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    function automatic string fmt_tag();
        case (cfg_fmt)
            2'b00:   return (cfg_len == 2'b00) ? "R4" : "R7";
            2'b10:   return (cfg_len == 2'b00) ? "R5" : "R7";
            2'b01:   return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] seen;
        logic [SW-1:0] ra_l, ra_r, rb_l, rb_r, ta_l, ta_r, tb_l, tb_r;
        int n0;

        repeat (6) @(negedge clk);
        // R1: outputs while reset is held
        check({rx_left, rx_right, rx_valid, tx_load, sdo} == '0, "R1 in reset",
              64'({rx_valid, tx_load, sdo}), 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs just after release with idle clocks
        check({rx_left, rx_right, rx_valid, tx_load, sdo} == '0, "R1 after reset",
              64'({rx_left, rx_right}), 64'd0);

        for (int c = 0; c < 64; c++) begin
            // R2/R3: both polarities swept together with every format and length
            cfg_fmt  = c[5:4];
            cfg_len  = c[3:2];
            cfg_wpol = c[1];
            cfg_bpol = c[0];
            ra_l = 24'hC6A4A7 ^ (24'(c) * 24'h01F3D5);
            ra_r = ~ra_l ^ 24'h00FF00;
            rb_l = 24'h813579 ^ (24'(c) << 7);
            rb_r = 24'h7E0F31 + 24'(c * 977);
            ta_l = 24'hB50F3C ^ (24'(c) << 3);
            ta_r = 24'h4AD2E1 - 24'(c * 313);
            tb_l = ~ta_r;
            tb_r = 24'h800001 | (24'(c) << 9);

            tx_left = '0; tx_right = '0;
            run_frame('0, '0, seen);

            tx_left = ta_l; tx_right = ta_r;
            n0 = load_n;
            run_frame(ra_l, ra_r, seen);
            // R9: zeros outside the word; word bits per the format
            check(seen == tx_expect(ta_l, ta_r), {fmt_tag(), " R9 tx frame A"},
                  seen, tx_expect(ta_l, ta_r));
            // R10: exactly one load pulse for the frame
            check(load_n - n0 == 1, "R10 load count", 64'(load_n - n0), 64'd1);

            tx_left = tb_l; tx_right = tb_r;
            n0 = cap_n;
            run_frame(rb_l, rb_r, seen);
            check(seen == tx_expect(tb_l, tb_r), {fmt_tag(), " R9 tx frame B"},
                  seen, tx_expect(tb_l, tb_r));
            // R8: pair from frame A with zero fill, one strobe
            check(cap_l == keep(ra_l) && cap_r == keep(ra_r) && cap_n - n0 == 1,
                  {fmt_tag(), " R8 rx frame A"}, {cap_l, cap_r, 16'(cap_n - n0)},
                  {keep(ra_l), keep(ra_r), 16'd1});

            tx_left = '0; tx_right = '0;
            run_frame('0, '0, seen);
            check(cap_l == keep(rb_l) && cap_r == keep(rb_r),
                  {fmt_tag(), " R8 rx frame B"}, {16'd0, cap_l, cap_r},
                  {16'd0, keep(rb_l), keep(rb_r)});
            // R11: ports still hold frame B pair at the end of the next frame
            check(rx_left == keep(rb_l) && rx_right == keep(rb_r), "R11 rx hold",
                  {16'd0, rx_left, rx_right}, {16'd0, keep(rb_l), keep(rb_r)});
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule